// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block is a bank of general-purpose I/O pins behind a small word-addressed register bus. Each pin has a direction bit, an output latch bit, an open-drain bit, a pull-up enable bit and a change-monitor enable bit, each held in its own register. Every register can be written in four ways: a plain replace, or an atomic clear, set or invert, where a 1 in the write data acts on the matching bit and a 0 leaves it alone. Software can therefore change single pins without a read-modify-write sequence.

Each pin can be handed to one alternate peripheral. While the peripheral is enabled and drives its output enable, the pad takes the peripheral's data and drive enable in place of the latch and direction bits. Pad inputs go through a two-stage synchronizer. The synchronized level feeds the peripheral input and the port read path. A change on any monitored pin, measured against the value captured at the last port read, raises a sticky interrupt. The logic needs only the bus clock, so it keeps working while the processor is asleep. The pull-up enable is only brought out as a control signal for the pad.

Top module: `gpio_port`

## Requirements
- R1: After reset, pad_oe, pad_pu and irq are all 0, and every register reads back as 0.
- R2: The address is {group[2:0], op[1:0]}. The groups are 0 direction, 1 port, 2 latch, 3 open-drain, 4 pull-up and 5 change-enable. Op 0 replaces the whole register with wr_data.
- R3: Op 1 clears, op 2 sets and op 3 inverts each register bit where wr_data is 1. Bits where wr_data is 0 keep their value.
- R4: Writes with any op to the port group act on the latch. A latch-group read returns the latch. A port-group read returns the synchronized pad level, not the latch.
- R5: On a pin without peripheral override or open-drain, a direction bit of 1 drives pad_oe=1 and pad_o=latch bit. A direction bit of 0 gives pad_oe=0.
- R6: With open-drain set on a driven pin, a data value of 1 releases the pad (pad_oe=0) and a data value of 0 drives it low (pad_oe=1, pad_o=0).
- R7: When per_en and per_oe are both 1 on a pin, the pad takes pad_o=per_do and pad_oe=1, whatever the direction bit. If either one is 0, the pin uses the latch and direction path.
- R8: per_di and the port read value follow pad_i after exactly two clock edges.
- R9: A difference between the synchronized level and the stored snapshot on a pin with change-enable 1 sets irq on the next edge. A difference on a pin with change-enable 0 has no effect. irq stays high until it is cleared.
- R10: A port-group read loads the snapshot with the synchronized level and clears irq on that same edge.
- R11: pad_pu equals the pull-up register at all times.
- R12: rd_data is registered and is valid in the cycle after rd_en. Any op code in the address reads the base register of its group. Groups 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address {group, op} |
| wr_data | input | N_PINS | Write data or bit mask |
| rd_data | output | N_PINS | Registered read data |
| pad_i | input | N_PINS | Raw pad input levels |
| pad_o | output | N_PINS | Pad output data |
| pad_oe | output | N_PINS | Pad drive enable |
| pad_pu | output | N_PINS | Weak pull-up enable to the pad |
| per_en | input | N_PINS | Peripheral module enable per pin |
| per_oe | input | N_PINS | Peripheral output enable per pin |
| per_do | input | N_PINS | Peripheral output data per pin |
| per_di | output | N_PINS | Synchronized pad level to the peripheral |
| irq | output | 1 | Sticky pin-change interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe, so pad_o, pad_oe and pad_pu are checked at the falling edge that follows. Read data is due one edge after rd_en: the scoreboard queues the expected word when the read is issued, and the monitor pops the queue at the next falling edge. A pad change shows on per_di two edges later and on irq three edges later. The bench checks each of those outputs one edge before its due time, expecting the old value, and again at the due time, expecting the new one. An irq cleared by a port read is expected low right after that read's edge and is checked again a few cycles later.

// File: rtl/gpio_pkg.sv
// Shared constants for the GPIO port: address groups and write op codes.
// Assumes a 5-bit word address split as {group[2:0], op[1:0]}.
package gpio_pkg;
    localparam int ADDR_W = 5;
    localparam int GRP_W  = 3;
    localparam int OP_W   = 2;
    localparam int NREG   = 5;   // stored registers: dir, lat, odc, pull, chgen

    localparam logic [GRP_W-1:0] GRP_DIR   = 3'd0;
    localparam logic [GRP_W-1:0] GRP_PORT  = 3'd1;
    localparam logic [GRP_W-1:0] GRP_LAT   = 3'd2;
    localparam logic [GRP_W-1:0] GRP_ODC   = 3'd3;
    localparam logic [GRP_W-1:0] GRP_PULL  = 3'd4;
    localparam logic [GRP_W-1:0] GRP_CHGEN = 3'd5;

    localparam logic [OP_W-1:0] OP_WR  = 2'd0;
    localparam logic [OP_W-1:0] OP_CLR = 2'd1;
    localparam logic [OP_W-1:0] OP_SET = 2'd2;
    localparam logic [OP_W-1:0] OP_INV = 2'd3;
endpackage

// File: rtl/gpio_ctl_regs.sv
// Control register file: direction, latch, open-drain, pull-up, change-enable.
// Each register accepts replace, clear, set and invert writes. Port-group
// writes are steered to the latch. Assumes one write per cycle.
module gpio_ctl_regs
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [GRP_W-1:0]     wr_grp,
    input  logic [OP_W-1:0]      wr_op,
    input  logic [N_PINS-1:0]    wr_data,
    output logic [N_PINS-1:0]    dir_q,
    output logic [N_PINS-1:0]    lat_q,
    output logic [N_PINS-1:0]    odc_q,
    output logic [N_PINS-1:0]    pull_q,
    output logic [N_PINS-1:0]    chgen_q
);
    logic [N_PINS-1:0] regs_q [NREG];
    logic [NREG-1:0]   hit;

    // Compute the new register value for one write op.
    function automatic logic [N_PINS-1:0] apply_op(input logic [N_PINS-1:0] cur,
                                                   input logic [N_PINS-1:0] wd,
                                                   input logic [OP_W-1:0]  op);
        case (op)
            OP_WR:   apply_op = wd;
            OP_CLR:  apply_op = cur & ~wd;
            OP_SET:  apply_op = cur | wd;
            default: apply_op = cur ^ wd;
        endcase
    endfunction

    // Decode which stored register the write group selects.
    always_comb begin
        hit    = '0;
        hit[0] = (wr_grp == GRP_DIR);
        hit[1] = (wr_grp == GRP_LAT) || (wr_grp == GRP_PORT);
        hit[2] = (wr_grp == GRP_ODC);
        hit[3] = (wr_grp == GRP_PULL);
        hit[4] = (wr_grp == GRP_CHGEN);
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Hold or update one register on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[r] <= '0;
            else if (wr_en && hit[r])
                regs_q[r] <= apply_op(regs_q[r], wr_data, wr_op);
        end
    end

    assign dir_q   = regs_q[0];
    assign lat_q   = regs_q[1];
    assign odc_q   = regs_q[2];
    assign pull_q  = regs_q[3];
    assign chgen_q = regs_q[4];
endmodule

// File: rtl/gpio_sync.sv
// Multi-stage input synchronizer for a vector of pad inputs.
// Assumes each bit is treated independently (no bus coherency).
module gpio_sync #(
    parameter int N_PINS = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] d,
    output logic [N_PINS-1:0] q
);
    logic [N_PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw pads.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // Later stages pass the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
// Per-pin output path: peripheral override, then open-drain shaping.
// Purely combinational; assumes the register and peripheral inputs are synchronous.
module gpio_pad_mux #(
    parameter int N_PINS = 8
) (
    input  logic [N_PINS-1:0] dir_q,
    input  logic [N_PINS-1:0] lat_q,
    input  logic [N_PINS-1:0] odc_q,
    input  logic [N_PINS-1:0] per_en,
    input  logic [N_PINS-1:0] per_oe,
    input  logic [N_PINS-1:0] per_do,
    output logic [N_PINS-1:0] pad_o,
    output logic [N_PINS-1:0] pad_oe
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic take_per;
        logic src_d;
        logic src_e;

        // Select the data and enable source, then apply open-drain.
        always_comb begin
            take_per = per_en[p] & per_oe[p];
            src_d    = take_per ? per_do[p] : lat_q[p];
            src_e    = take_per ? 1'b1      : dir_q[p];
            if (odc_q[p]) begin
                pad_o[p]  = 1'b0;
                pad_oe[p] = src_e & ~src_d;
            end else begin
                pad_o[p]  = src_d;
                pad_oe[p] = src_e;
            end
        end
    end
endmodule

// File: rtl/gpio_chg_det.sv
// Pin-change detector with snapshot register and sticky interrupt flag.
// Assumes snap_ld pulses for one cycle per port read.
module gpio_chg_det #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_s,
    input  logic [N_PINS-1:0] chgen_q,
    input  logic              snap_ld,
    output logic              irq
);
    logic [N_PINS-1:0] snap_q;
    logic              flag_q;
    logic              diff_any;

    // Any monitored pin differing from the snapshot.
    always_comb diff_any = |((pin_s ^ snap_q) & chgen_q);

    // Snapshot follows the level captured by each port read.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (snap_ld) snap_q <= pin_s;
    end

    // Sticky flag: set on a monitored difference, cleared by a port read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (snap_ld) flag_q <= 1'b0;
        else if (diff_any) flag_q <= 1'b1;
    end

    assign irq = flag_q;
endmodule

// File: rtl/gpio_port.sv
// GPIO port top: bus decode, register file, synchronizer, pad mux,
// change detector and registered read path. Assumes a single bus master
// with at most one read or write per cycle.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wr_data,
    output logic [N_PINS-1:0] rd_data,
    input  logic [N_PINS-1:0] pad_i,
    output logic [N_PINS-1:0] pad_o,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pu,
    input  logic [N_PINS-1:0] per_en,
    input  logic [N_PINS-1:0] per_oe,
    input  logic [N_PINS-1:0] per_do,
    output logic [N_PINS-1:0] per_di,
    output logic              irq
);
    logic [GRP_W-1:0]  grp;
    logic [OP_W-1:0]   op;
    logic [N_PINS-1:0] dir_q, lat_q, odc_q, pull_q, chgen_q;
    logic [N_PINS-1:0] pin_s;
    logic [N_PINS-1:0] rd_mux;
    logic              port_rd;

    assign grp = addr[ADDR_W-1:OP_W];
    assign op  = addr[OP_W-1:0];

    gpio_ctl_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(grp), .wr_op(op),
        .wr_data(wr_data), .dir_q(dir_q), .lat_q(lat_q), .odc_q(odc_q),
        .pull_q(pull_q), .chgen_q(chgen_q)
    );

    gpio_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_i), .q(pin_s)
    );

    gpio_pad_mux #(.N_PINS(N_PINS)) u_mux (
        .dir_q(dir_q), .lat_q(lat_q), .odc_q(odc_q), .per_en(per_en),
        .per_oe(per_oe), .per_do(per_do), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // Port read strobe drives snapshot load and interrupt clear.
    always_comb port_rd = rd_en && (grp == GRP_PORT);

    gpio_chg_det #(.N_PINS(N_PINS)) u_chg (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .chgen_q(chgen_q),
        .snap_ld(port_rd), .irq(irq)
    );

    // Select the readback word for the addressed group.
    always_comb begin
        case (grp)
            GRP_DIR:   rd_mux = dir_q;
            GRP_PORT:  rd_mux = pin_s;
            GRP_LAT:   rd_mux = lat_q;
            GRP_ODC:   rd_mux = odc_q;
            GRP_PULL:  rd_mux = pull_q;
            GRP_CHGEN: rd_mux = chgen_q;
            default:   rd_mux = '0;
        endcase
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    assign pad_pu = pull_q;
    assign per_di = pin_s;
endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for gpio_port, attached by bind. Observes ports and the
// latch and open-drain registers.
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [N_PINS-1:0] wr_data,
    input logic [N_PINS-1:0] pad_i,
    input logic [N_PINS-1:0] pad_o,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] per_en,
    input logic [N_PINS-1:0] per_oe,
    input logic [N_PINS-1:0] per_do,
    input logic [N_PINS-1:0] per_di,
    input logic              irq,
    input logic [N_PINS-1:0] lat_q,
    input logic [N_PINS-1:0] odc_q
);
    logic [1:0] cyc_q;
    logic [N_PINS-1:0] ovr;

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    always_comb ovr = per_en & per_oe & ~odc_q;

    a_r1_reset_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && !irq));

    a_r3_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {GRP_LAT, OP_SET}) |=> (lat_q == ($past(lat_q) | $past(wr_data))));

    a_r3_clr_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == {GRP_LAT, OP_CLR}) |=> (lat_q == ($past(lat_q) & ~$past(wr_data))));

    a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_o & odc_q) == '0));

    a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_o & ovr) == (per_do & ovr)) && ((pad_oe & ovr) == ovr)));

    a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (per_di == $past(pad_i, 2)));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1:OP_W] == GRP_PORT) |=> !irq);
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .per_en(per_en), .per_oe(per_oe), .per_do(per_do), .per_di(per_di),
    .irq(irq), .lat_q(lat_q), .odc_q(odc_q)
);

// File: tb/gpio_port_tb.sv
// Scoreboard bench for gpio_port: reads queue expected words, a monitor
// compares them one edge later; pad and irq outputs are checked directly.
module gpio_port_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [N-1:0] wr_data = '0, rd_data;
    logic [N-1:0] pad_i = '0, pad_o, pad_oe, pad_pu;
    logic [N-1:0] per_en = '0, per_oe = '0, per_do = '0, per_di;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    always #4 clk = ~clk;

    gpio_port #(.N_PINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pad_i(pad_i), .pad_o(pad_o),
        .pad_oe(pad_oe), .pad_pu(pad_pu), .per_en(per_en), .per_oe(per_oe),
        .per_do(per_do), .per_di(per_di), .irq(irq)
    );

    function automatic logic [4:0] ad(input int g, input int o);
        ad = 5'((g << 2) | o);
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [N-1:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: each read's word is due at the falling edge after its clock edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12 unexpected read actual=%h expected=none", rd_data);
                end else begin
                    check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 pad_pu", pad_pu, '0);
        check("R1 irq", {7'd0, irq}, '0);
        rd(ad(0, 0), 8'h00, "R1 dir read");
        rd(ad(2, 0), 8'h00, "R1 latch read");
        // R2 replace write, R12 alias read
        wr(ad(0, 0), 8'hA5);
        rd(ad(0, 0), 8'hA5, "R2 dir replace");
        rd(ad(0, 2), 8'hA5, "R12 alias reads base");
        // R3 clear/set/invert
        wr(ad(0, 1), 8'h05);
        rd(ad(0, 0), 8'hA0, "R3 clear");
        wr(ad(0, 2), 8'h0F);
        rd(ad(0, 0), 8'hAF, "R3 set");
        wr(ad(0, 3), 8'hFF);
        rd(ad(0, 0), 8'h50, "R3 invert");
        // R4 port writes hit latch; port read shows pads
        wr(ad(1, 0), 8'h3C);
        wr(ad(1, 3), 8'h01);
        rd(ad(2, 0), 8'h3D, "R4 latch via port write");
        rd(ad(1, 0), 8'h00, "R4 port read shows pads");
        // R5 direction path: dir=50 lat=3D
        check("R5 pad_oe", pad_oe, 8'h50);
        check("R5 pad_o", pad_o & pad_oe, 8'h10);
        // R6 open-drain on pins 4 (lat 1) and 6 (lat 0)
        wr(ad(3, 0), 8'h50);
        check("R6 pad_oe", pad_oe, 8'h40);
        check("R6 pad_o", pad_o & pad_oe, 8'h00);
        rd(ad(3, 3), 8'h50, "R12 odc alias read");
        // R7 peripheral override on pin 0
        per_en = 8'h01; per_oe = 8'h01; per_do = 8'h01;
        #1;
        check("R7 override oe", pad_oe, 8'h41);
        check("R7 override data", pad_o & 8'h01, 8'h01);
        per_oe = 8'h00;
        #1;
        check("R7 no oe falls back", pad_oe, 8'h40);
        per_en = 8'h00; per_oe = 8'h01;
        #1;
        check("R7 no enable falls back", pad_oe, 8'h40);
        per_oe = 8'h00;
        // R8 two-edge synchronizer
        @(negedge clk);
        pad_i = 8'h96;
        idle(1);
        check("R8 one edge old", per_di, 8'h00);
        idle(1);
        check("R8 two edges new", per_di, 8'h96);
        rd(ad(1, 0), 8'h96, "R8 port read");
        // R11 pull-up output
        wr(ad(4, 0), 8'h81);
        check("R11 pad_pu", pad_pu, 8'h81);
        // R9 change detection on pin 1 only
        wr(ad(5, 0), 8'h02);
        pad_i = 8'h97;
        idle(4);
        check("R9 disabled pin ignored", {7'd0, irq}, 8'h00);
        pad_i = 8'h95;
        idle(2);
        check("R9 irq not yet", {7'd0, irq}, 8'h00);
        idle(1);
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        idle(2);
        check("R9 irq sticky", {7'd0, irq}, 8'h01);
        // R10 port read clears irq and refreshes snapshot
        rd(ad(1, 0), 8'h95, "R10 port read value");
        check("R10 irq cleared", {7'd0, irq}, 8'h00);
        idle(3);
        check("R10 stays clear", {7'd0, irq}, 8'h00);
        // R12 unmapped group
        rd(ad(6, 0), 8'h00, "R12 unmapped read");
        rd(ad(7, 1), 8'h00, "R12 unmapped read 2");
        idle(3);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12 missing reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule